// File: doc/BRIEF.md
# Load/Store Effective-Address Unit

This block forms the memory address for a single-register load or store and the new value of the base register. It takes a base value and an offset that comes either from a 12-bit unsigned immediate field or from a full second register. The offset is added to the base or subtracted from it. Three indexing forms are supported. Pre-indexed access uses the offset address and leaves the base alone. Pre-indexed access with writeback uses the offset address and also writes it back to the base. Post-indexed access uses the untouched base and then updates the base with the offset result.

An operation is accepted when `op_valid` is high while `op_ready` is high. On the next cycle the unit raises a memory request and holds it until `mem_ready` is sampled high. In the cycle after that handshake, the unit pulses the base writeback strobe for the indexing forms that update the base. For loads it also pulses a load-result strobe, which carries the returned word and the destination register index. The register file, the decoder and the memory are outside the block.

Top module: `agu_ldst`

## Requirements
- R1: When `op_off_is_reg` is 0, the offset is `op_imm` zero-extended to 32 bits. When it is 1, the offset is the full 32-bit `op_offreg`.
- R2: The offset is added to the base when `op_sub` is 0 and subtracted from the base when `op_sub` is 1.
- R3: With `op_pre`=1 and `op_wb`=0, `mem_addr` is base±offset and `base_wr_en` stays low for the whole operation.
- R4: With `op_pre`=1 and `op_wb`=1, `mem_addr` is base±offset. The same value appears on `base_wr_data`, with `base_wr_idx` equal to `op_base_idx`.
- R5: With `op_pre`=0 (whatever `op_wb` is), `mem_addr` is the unmodified base. `base_wr_data` is base±offset, with `base_wr_idx` equal to `op_base_idx`.
- R6: All address arithmetic wraps modulo 2^32 and raises no fault.
- R7: `mem_req` rises in the cycle after acceptance. For a store, `mem_we`=1 and `mem_wdata`=`op_store_data`; for a load, `mem_we`=0. Address, direction and write data hold stable while `mem_req` is high and `mem_ready` is low.
- R8: For a load, `ld_valid` is high for exactly the one cycle after the handshake, with `ld_data` equal to the `mem_rdata` sampled at the handshake and `ld_idx` equal to `op_rd`. For a store, it stays low.
- R9: `base_wr_en` is high for exactly the one cycle after the handshake, and only in the R4 and R5 forms.
- R10: `op_ready` is low from acceptance until the handshake, and `op_valid` has no effect during that time. After reset, `op_ready`=1 and `mem_req`, `base_wr_en` and `ld_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation accepted this cycle if offered |
| op_is_load | input | 1 | 1 = load, 0 = store |
| op_base | input | 32 | Base register value |
| op_base_idx | input | 4 | Base register index |
| op_imm | input | 12 | Unsigned immediate offset |
| op_offreg | input | 32 | Register offset value |
| op_off_is_reg | input | 1 | Offset source select |
| op_sub | input | 1 | Subtract offset |
| op_pre | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| op_wb | input | 1 | Base writeback for pre-indexed |
| op_rd | input | 4 | Load destination / store source index |
| op_store_data | input | 32 | Store data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | 32 | Effective address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory handshake |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| base_wr_en | output | 1 | Base writeback strobe |
| base_wr_idx | output | 4 | Base register to write |
| base_wr_data | output | 32 | Updated base value |
| ld_valid | output | 1 | Load result strobe |
| ld_idx | output | 4 | Load destination index |
| ld_data | output | 32 | Loaded word |

## Verification
The bench runs every combination of load or store, immediate or register offset, add or subtract, and the three indexing forms. Each combination is tried on four base/offset pairs. The pairs include carry past the top of the address space, borrow below zero, and the largest immediate. Comparing the access address with the writeback value separates pre-indexing from post-indexing. Comparing a large immediate with a large register value exposes truncation or sign extension of the offset. Memory wait states from zero to three cycles, with `op_valid` held high during them, show that the request stays stable and that new offers are ignored while busy.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic [0:0] {
        AGU_IDLE = 1'b0,
        AGU_REQ  = 1'b1
    } agu_fsm_e;
endpackage

// File: rtl/agu_offset_unit.sv
module agu_offset_unit #(
    parameter int ADDR_W        = 32,
    parameter int IMM_W         = 12,
    parameter bit SHARED_ADDER  = 1'b1
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] offreg_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_reg_i,
    input  logic              sub_i,
    output logic [ADDR_W-1:0] sum_o
);
    localparam int PAD_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = use_reg_i ? offreg_i : {{PAD_W{1'b0}}, imm_i};
    end

    generate
        if (SHARED_ADDER) begin : g_shared
            // one carry chain: invert operand and inject carry for subtraction
            logic [ADDR_W-1:0] opnd;
            logic [ADDR_W-1:0] cin;
            always_comb begin
                opnd  = offset ^ {ADDR_W{sub_i}};
                cin   = {{(ADDR_W-1){1'b0}}, sub_i};
                sum_o = base_i + opnd + cin;
            end
        end else begin : g_split
            logic [ADDR_W-1:0] up_sum;
            logic [ADDR_W-1:0] dn_sum;
            always_comb begin
                up_sum = base_i + offset;
                dn_sum = base_i - offset;
                sum_o  = sub_i ? dn_sum : up_sum;
            end
        end
    endgenerate
endmodule

// File: rtl/agu_index_mode.sv
module agu_index_mode #(
    parameter int ADDR_W = 32
) (
    input  logic              pre_i,
    input  logic              wb_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] sum_i,
    output logic [ADDR_W-1:0] access_o,
    output logic [ADDR_W-1:0] nbase_o,
    output logic              upd_o
);
    always_comb begin
        access_o = pre_i ? sum_i : base_i;
        nbase_o  = sum_i;
        upd_o    = (!pre_i) || wb_i;
    end
endmodule

// File: rtl/agu_ldst.sv
module agu_ldst
    import agu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic              op_is_load,
    input  logic [DATA_W-1:0] op_base,
    input  logic [IDX_W-1:0]  op_base_idx,
    input  logic [IMM_W-1:0]  op_imm,
    input  logic [DATA_W-1:0] op_offreg,
    input  logic              op_off_is_reg,
    input  logic              op_sub,
    input  logic              op_pre,
    input  logic              op_wb,
    input  logic [IDX_W-1:0]  op_rd,
    input  logic [DATA_W-1:0] op_store_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              base_wr_en,
    output logic [IDX_W-1:0]  base_wr_idx,
    output logic [DATA_W-1:0] base_wr_data,
    output logic              ld_valid,
    output logic [IDX_W-1:0]  ld_idx,
    output logic [DATA_W-1:0] ld_data
);
    typedef struct packed {
        agu_fsm_e          fsm;
        logic [DATA_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] nbase;
        logic              upd;
        logic [IDX_W-1:0]  rn;
        logic [IDX_W-1:0]  rd;
        logic              wb_pulse;
        logic              ld_pulse;
        logic [DATA_W-1:0] ld_word;
    } agu_state_t;

    agu_state_t st_d, st_q;

    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] access_w;
    logic [DATA_W-1:0] nbase_w;
    logic              upd_w;

    agu_offset_unit #(
        .ADDR_W       (DATA_W),
        .IMM_W        (IMM_W),
        .SHARED_ADDER (1'b1)
    ) u_offset (
        .base_i    (op_base),
        .offreg_i  (op_offreg),
        .imm_i     (op_imm),
        .use_reg_i (op_off_is_reg),
        .sub_i     (op_sub),
        .sum_o     (sum_w)
    );

    agu_index_mode #(
        .ADDR_W (DATA_W)
    ) u_mode (
        .pre_i    (op_pre),
        .wb_i     (op_wb),
        .base_i   (op_base),
        .sum_i    (sum_w),
        .access_o (access_w),
        .nbase_o  (nbase_w),
        .upd_o    (upd_w)
    );

    always_comb begin
        st_d          = st_q;
        st_d.wb_pulse = 1'b0;
        st_d.ld_pulse = 1'b0;
        case (st_q.fsm)
            AGU_IDLE: begin
                if (op_valid) begin
                    st_d.fsm   = AGU_REQ;
                    st_d.addr  = access_w;
                    st_d.we    = !op_is_load;
                    st_d.wdata = op_store_data;
                    st_d.nbase = nbase_w;
                    st_d.upd   = upd_w;
                    st_d.rn    = op_base_idx;
                    st_d.rd    = op_rd;
                end
            end
            AGU_REQ: begin
                if (mem_ready) begin
                    st_d.fsm      = AGU_IDLE;
                    st_d.wb_pulse = st_q.upd;
                    st_d.ld_pulse = !st_q.we;
                    if (!st_q.we) begin
                        st_d.ld_word = mem_rdata;
                    end
                end
            end
            default: st_d.fsm = AGU_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        op_ready     = (st_q.fsm == AGU_IDLE);
        mem_req      = (st_q.fsm == AGU_REQ);
        mem_we       = st_q.we;
        mem_addr     = st_q.addr;
        mem_wdata    = st_q.wdata;
        base_wr_en   = st_q.wb_pulse;
        base_wr_idx  = st_q.rn;
        base_wr_data = st_q.nbase;
        ld_valid     = st_q.ld_pulse;
        ld_idx       = st_q.rd;
        ld_data      = st_q.ld_word;
    end
endmodule

// File: rtl/agu_ldst_chk.sv
module agu_ldst_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              base_wr_en,
    input logic              ld_valid
);
    // R7: request fields frozen while waiting
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R7: acceptance leads to a request next cycle
    a_r7_req_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |=> mem_req);

    // R8: load strobe follows a read handshake, one cycle wide
    a_r8_ld_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_req && mem_ready && !mem_we));
    a_r8_ld_single: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !ld_valid);

    // R9: writeback strobe follows a handshake, one cycle wide
    a_r9_wb_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr_en |-> $past(mem_req && mem_ready));
    a_r9_wb_single: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr_en |=> !base_wr_en);

    // R10: no acceptance while a request is outstanding
    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !op_ready);
endmodule

bind agu_ldst agu_ldst_chk #(.DATA_W(DATA_W)) u_agu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_ready   (op_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .base_wr_en (base_wr_en),
    .ld_valid   (ld_valid)
);

// File: tb/agu_ldst_bench.sv
`timescale 1ns/1ps
module agu_ldst_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic        op_is_load = 1'b0;
    logic [31:0] op_base = '0;
    logic [3:0]  op_base_idx = '0;
    logic [11:0] op_imm = '0;
    logic [31:0] op_offreg = '0;
    logic        op_off_is_reg = 1'b0;
    logic        op_sub = 1'b0;
    logic        op_pre = 1'b0;
    logic        op_wb = 1'b0;
    logic [3:0]  op_rd = '0;
    logic [31:0] op_store_data = '0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        base_wr_en;
    logic [3:0]  base_wr_idx;
    logic [31:0] base_wr_data;
    logic        ld_valid;
    logic [3:0]  ld_idx;
    logic [31:0] ld_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    agu_ldst u_agu_ldst (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input bit ld, input logic [31:0] base, input logic [11:0] imm,
                          input logic [31:0] oreg, input bit use_reg, input bit sub,
                          input int mode, input int waits, input logic [31:0] sdata,
                          input logic [31:0] rdata);
        logic [31:0] off, sum, exp_addr;
        bit pre, wb, upd;
        pre = (mode != 2);
        wb  = (mode == 1);
        upd = !pre || wb;
        off = use_reg ? oreg : {20'd0, imm};           // R1
        sum = sub ? (base - off) : (base + off);        // R2, R6 (32-bit wrap)
        exp_addr = pre ? sum : base;                    // R3 R4 R5
        @(negedge clk);
        check(op_ready == 1'b1, "R10 idle before offer", {31'd0, op_ready}, 32'd1);
        op_valid = 1'b1; op_is_load = ld; op_base = base; op_imm = imm;
        op_offreg = oreg; op_off_is_reg = use_reg; op_sub = sub;
        op_pre = pre; op_wb = wb; op_base_idx = base[3:0] ^ 4'h5;
        op_rd = sdata[3:0]; op_store_data = sdata;
        @(negedge clk);
        op_valid = 1'b0;
        check(mem_req == 1'b1, "R7 request raised", {31'd0, mem_req}, 32'd1);
        check(mem_addr == exp_addr, pre ? (wb ? "R4 address" : "R3 address") : "R5 address", mem_addr, exp_addr);
        check(mem_we == !ld, "R7 direction", {31'd0, mem_we}, {31'd0, !ld});
        if (!ld) check(mem_wdata == sdata, "R7 write data", mem_wdata, sdata);
        for (int w = 0; w < waits; w++) begin
            // R10: offers during busy must be ignored
            op_valid = 1'b1; op_base = ~base; op_imm = ~imm; op_is_load = !ld;
            @(negedge clk);
            check(op_ready == 1'b0, "R10 busy", {31'd0, op_ready}, 32'd0);
            check(mem_req && mem_addr == exp_addr, "R7 R10 address hold", mem_addr, exp_addr);
            check(mem_we == !ld, "R7 direction hold", {31'd0, mem_we}, {31'd0, !ld});
        end
        op_valid = 1'b0;
        mem_ready = 1'b1; mem_rdata = rdata;
        @(negedge clk);
        mem_ready = 1'b0; mem_rdata = 32'hDEAD_BEEF;
        check(mem_req == 1'b0, "R7 request dropped", {31'd0, mem_req}, 32'd0);
        check(base_wr_en == upd, "R9 writeback strobe", {31'd0, base_wr_en}, {31'd0, upd});
        if (upd) begin
            check(base_wr_data == sum, pre ? "R4 writeback value" : "R5 writeback value", base_wr_data, sum);
            check(base_wr_idx == (base[3:0] ^ 4'h5), "R4 R5 writeback index", {28'd0, base_wr_idx}, {28'd0, base[3:0] ^ 4'h5});
        end
        check(ld_valid == ld, "R8 load strobe", {31'd0, ld_valid}, {31'd0, ld});
        if (ld) begin
            check(ld_data == rdata, "R8 load data", ld_data, rdata);
            check(ld_idx == sdata[3:0], "R8 load index", {28'd0, ld_idx}, {28'd0, sdata[3:0]});
        end
        @(negedge clk);
        check(base_wr_en == 1'b0, "R9 strobe width", {31'd0, base_wr_en}, 32'd0);
        check(ld_valid == 1'b0, "R8 strobe width", {31'd0, ld_valid}, 32'd0);
    endtask

    initial begin
        logic [31:0] bases [4];
        logic [11:0] imms  [4];
        logic [31:0] oregs [4];
        bases[0] = 32'h0000_1000; imms[0] = 12'h004; oregs[0] = 32'h0000_0100;
        bases[1] = 32'hFFFF_FFF0; imms[1] = 12'h020; oregs[1] = 32'h0000_0040;  // R6 carry out
        bases[2] = 32'h0000_0004; imms[2] = 12'hFFF; oregs[2] = 32'h8000_0010;  // R6 borrow, R1 width
        bases[3] = 32'h8000_0000; imms[3] = 12'h800; oregs[3] = 32'hFFFF_F000;
        repeat (3) @(negedge clk);
        check(op_ready == 1'b1, "R10 reset ready", {31'd0, op_ready}, 32'd1);
        check(mem_req == 1'b0, "R10 reset request", {31'd0, mem_req}, 32'd0);
        check(base_wr_en == 1'b0 && ld_valid == 1'b0, "R10 reset strobes", {30'd0, base_wr_en, ld_valid}, 32'd0);
        rst_n = 1'b1;
        for (int p = 0; p < 4; p++)
            for (int ld = 0; ld < 2; ld++)
                for (int ur = 0; ur < 2; ur++)
                    for (int sb = 0; sb < 2; sb++)
                        for (int md = 0; md < 3; md++)
                            run_op(ld[0], bases[p], imms[p], oregs[p], ur[0], sb[0], md,
                                   (p + md + ld) % 4, 32'hA5A5_0000 + 32'(p * 16 + md * 4 + ur * 2 + sb),
                                   32'h1357_0000 ^ 32'(p * 97 + md));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule